// File: doc/BRIEF.md
# Dual-Select Asynchronous Static RAM Emulator

This block models an 8K-by-8 static RAM that is driven through pin-level, unclocked control inputs. It is meant to sit inside a larger clocked design and serve an external or legacy bus master that expects a plain asynchronous memory. A fast internal clock samples the address, the two chip-select inputs, the write strobe, the output-enable strobe and the incoming data bus. From these samples it decodes the operating mode, watches for the write window, and drives or releases the outgoing data bus through an enable signal meant for a tri-state pad.

The chip is selected only when the active-low select is low and the active-high select is high. A write window is open while the chip is selected and the write strobe is low. The window opens at whichever of those conditions becomes true last and closes at whichever becomes false first. The byte is committed to the array only when the window closes. The value stored is the data that was sampled on the last internal clock before the window closed, which models a zero data-hold time.

Storage is organised as 256 rows of 256 bits. Eight address bits pick a row and five pick one of 32 byte lanes in that row. The read path follows the synchronised address combinationally, so the driven byte tracks every address change.

Top module: `sram_emu`

## Requirements
- R1: The block is selected only when `cs1_n_i` is 0 and `cs2_i` is 1. With any other select combination, `dq_oe_o` is 0 whatever `we_n_i` and `oe_n_i` are.
- R2: When selected with `we_n_i`=1 and `oe_n_i`=0, `dq_oe_o` is 1 and `dq_o` carries the byte stored at `addr_i`, no later than two clock edges after the pins settle.
- R3: When selected with `we_n_i`=1 and `oe_n_i`=1, `dq_oe_o` is 0.
- R4: When selected with `we_n_i`=0, `dq_oe_o` is 0 for either level of `oe_n_i`.
- R5: A write commits `dq_i` to `addr_i` when the window closes. Any of three events closes it: `we_n_i` rising, `cs1_n_i` rising or `cs2_i` falling.
- R6: The stored byte is the one on `dq_i` on the last sampled clock before the window closed. A new value applied at the same moment the window closes is not stored, and an earlier value replaced during the window is not stored either.
- R7: The row index is {A12, A11, A9..A4} and the byte lane is {A10, A3..A0}. Addresses that differ only in A10 or only in A11 hold independent bytes.
- R8: A window that opens because a select becomes active while `we_n_i` is already low still writes. `dq_oe_o` stays 0 for the whole of that write, even with `oe_n_i`=0.
- R9: While reading, a change of `addr_i` alone shows the new location's byte on `dq_o` two clock edges later.
- R10: After reset, `dq_oe_o` is 0.
- R11: Pulsing `we_n_i` low while deselected leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 13 | Byte address |
| cs1_n_i | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dq_i | input | 8 | Data bus as seen at the pad input |
| dq_o | output | 8 | Data to drive onto the bus |
| dq_oe_o | output | 1 | Pad output enable for `dq_o` |

## Verification
Every pin passes through two synchroniser flops, so the mode and the read byte react two rising edges after a pin change. A write commits one edge after the synchronised window is seen to close, which makes the new byte readable within four edges. The bench changes pins only on falling edges and waits three falling edges before each sample. Each sample is therefore taken at least half a cycle after the last register on the path has settled. The expected enable and byte for that sample are queued by the driver and compared by the monitor at that point.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    localparam int ADDR_W    = 13;
    localparam int DATA_W    = 8;
    localparam int ROW_W     = 8;
    localparam int COL_W     = ADDR_W - ROW_W;
    localparam int ROWS      = 1 << ROW_W;
    localparam int LANES     = 1 << COL_W;
    localparam int ROW_BITS  = LANES * DATA_W;

    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic we_n;
        logic oe_n;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    localparam pins_t PINS_IDLE = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1, oe_n: 1'b1};

    typedef enum logic [1:0] {
        MD_IDLE  = 2'd0,
        MD_HIZ   = 2'd1,
        MD_READ  = 2'd2,
        MD_WRITE = 2'd3
    } mode_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } loc_t;

    function automatic mode_e decode_mode(pins_t p);
        mode_e m;
        if (p.cs1_n || !p.cs2)  m = MD_IDLE;
        else if (!p.we_n)       m = MD_WRITE;
        else if (p.oe_n)        m = MD_HIZ;
        else                    m = MD_READ;
        return m;
    endfunction

    function automatic loc_t split_addr(logic [ADDR_W-1:0] a);
        loc_t l;
        l.row = {a[12], a[11], a[9:4]};
        l.col = {a[10], a[3:0]};
        return l;
    endfunction

endpackage

// File: rtl/sram_emu_sync.sv
module sram_emu_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
    import sram_emu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pins_t             pins_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output mode_e             mode,
    output logic              win_open,
    output logic              commit_en,
    output loc_t              commit_loc,
    output logic [DATA_W-1:0] commit_data
);

    logic              win_q;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    always_comb begin
        mode     = decode_mode(pins_s);
        win_open = (mode == MD_WRITE);
    end

    // Previous window level; a falling window level is the close event.
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= 1'b0;
        end else begin
            win_q <= win_open;
        end
    end

    // Track bus and address on every clock the window is open.
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (win_open) begin
            cap_addr <= addr_s;
            cap_data <= data_s;
        end
    end

    always_comb begin
        commit_en   = win_q && !win_open;
        commit_loc  = split_addr(cap_addr);
        commit_data = cap_data;
    end

endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array
    import sram_emu_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  loc_t              wr_loc,
    input  logic [DATA_W-1:0] wr_data,
    input  loc_t              rd_loc,
    output logic [DATA_W-1:0] rd_data
);

    logic [ROW_BITS-1:0] rows [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            rows[wr_loc.row][wr_loc.col*DATA_W +: DATA_W] <= wr_data;
        end
    end

    logic [ROW_BITS-1:0] rd_row;

    always_comb begin
        rd_row  = rows[rd_loc.row];
        rd_data = rd_row[rd_loc.col*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/sram_emu.sv
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs1_n_i,
    input  logic              cs2_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o
);

    pins_t             pins_raw;
    pins_t             pins_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    mode_e             mode;
    logic              win_open;
    logic              commit_en;
    loc_t              commit_loc;
    logic [DATA_W-1:0] commit_data;
    loc_t              rd_loc;
    logic [DATA_W-1:0] rd_data;

    assign pins_raw = '{cs1_n: cs1_n_i, cs2: cs2_i, we_n: we_n_i, oe_n: oe_n_i};

    sram_emu_sync #(.W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync_pins (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    sram_emu_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
        .clk (clk),
        .rst (rst),
        .d   (addr_i),
        .q   (addr_s)
    );

    sram_emu_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
        .clk (clk),
        .rst (rst),
        .d   (dq_i),
        .q   (data_s)
    );

    sram_emu_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .pins_s      (pins_s),
        .addr_s      (addr_s),
        .data_s      (data_s),
        .mode        (mode),
        .win_open    (win_open),
        .commit_en   (commit_en),
        .commit_loc  (commit_loc),
        .commit_data (commit_data)
    );

    assign rd_loc = split_addr(addr_s);

    sram_emu_array u_array (
        .clk     (clk),
        .wr_en   (commit_en),
        .wr_loc  (commit_loc),
        .wr_data (commit_data),
        .rd_loc  (rd_loc),
        .rd_data (rd_data)
    );

    assign dq_o    = rd_data;
    assign dq_oe_o = (mode == MD_READ);

endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk (
    input logic clk,
    input logic rst,
    input logic cs1_n_i,
    input logic cs2_i,
    input logic we_n_i,
    input logic oe_n_i,
    input logic dq_oe_o,
    input logic win_open
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    logic warm;
    assign warm = (age >= 2'd2);

    AST_DESEL_FLOATS: assert property (@(posedge clk) disable iff (rst)
        (warm && !(!$past(cs1_n_i, 2) && $past(cs2_i, 2))) |-> !dq_oe_o); // R1

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(cs1_n_i, 2) && $past(cs2_i, 2) && $past(we_n_i, 2) && !$past(oe_n_i, 2))
        |-> dq_oe_o); // R2

    AST_OUT_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(oe_n_i, 2)) |-> !dq_oe_o); // R3

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(we_n_i, 2)) |-> !dq_oe_o); // R4

    AST_WINDOW_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        (warm && win_open) |-> (!$past(cs1_n_i, 2) && $past(cs2_i, 2) && !$past(we_n_i, 2))); // R5

    AST_WINDOW_HIZ: assert property (@(posedge clk) disable iff (rst)
        win_open |-> !dq_oe_o); // R8

endmodule

bind sram_emu sram_emu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs1_n_i  (cs1_n_i),
    .cs2_i    (cs2_i),
    .we_n_i   (we_n_i),
    .oe_n_i   (oe_n_i),
    .dq_oe_o  (dq_oe_o),
    .win_open (win_open)
);

// File: tb/sram_emu_tb.sv
module sram_emu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] addr_i;
    logic        cs1_n_i, cs2_i, we_n_i, oe_n_i;
    logic [7:0]  dq_i;
    logic [7:0]  dq_o;
    logic        dq_oe_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_emu u_dut (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (addr_i),
        .cs1_n_i (cs1_n_i),
        .cs2_i   (cs2_i),
        .we_n_i  (we_n_i),
        .oe_n_i  (oe_n_i),
        .dq_i    (dq_i),
        .dq_o    (dq_o),
        .dq_oe_o (dq_oe_o)
    );

    typedef struct {
        bit         exp_oe;
        bit         chk_data;
        logic [7:0] exp_d;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    // Monitor: compares each queued expectation against the outputs.
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                checks++;
                if (dq_oe_o !== it.exp_oe) begin
                    errors++;
                    $display("FAIL %s: dq_oe_o actual %0b expected %0b", it.req, dq_oe_o, it.exp_oe);
                end else if (it.chk_data && dq_o !== it.exp_d) begin
                    errors++;
                    $display("FAIL %s: dq_o actual %02h expected %02h", it.req, dq_o, it.exp_d);
                end
            end
        end
    end

    task automatic push(bit oe, bit chkd, logic [7:0] d, string r);
        exp_t it;
        it.exp_oe = oe; it.chk_data = chkd; it.exp_d = d; it.req = r;
        exp_q.push_back(it);
        -> sample_ev;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic go_idle();
        cs1_n_i = 1'b1; cs2_i = 1'b0; we_n_i = 1'b1; oe_n_i = 1'b1;
    endtask

    task automatic read_chk(logic [12:0] a, logic [7:0] d, string r);
        addr_i = a; cs1_n_i = 1'b0; cs2_i = 1'b1; we_n_i = 1'b1; oe_n_i = 1'b0;
        settle();
        push(1'b1, 1'b1, d, r);
    endtask

    // kind: 0 closes by write strobe, 1 by active-low select, 2 by active-high select
    task automatic write_byte(logic [12:0] a, logic [7:0] d, int kind, string r);
        oe_n_i = 1'b1; addr_i = a; dq_i = d;
        cs1_n_i = 1'b0; cs2_i = 1'b1; we_n_i = 1'b1;
        settle();
        we_n_i = 1'b0;
        settle();
        push(1'b0, 1'b0, 8'h00, "R4");
        case (kind)
            0:       we_n_i  = 1'b1;
            1:       cs1_n_i = 1'b1;
            default: cs2_i   = 1'b0;
        endcase
        settle();
        go_idle();
        settle();
        push(1'b0, 1'b0, 8'h00, r);
    endtask

    initial begin
        rst = 1'b1; addr_i = '0; dq_i = '0;
        go_idle();
        repeat (4) @(negedge clk);
        push(1'b0, 1'b0, 8'h00, "R10");
        rst = 1'b0;
        settle();
        push(1'b0, 1'b0, 8'h00, "R10");

        // R5: each of the three closing events commits the byte
        write_byte(13'h0000, 8'h5A, 0, "R5");
        read_chk(13'h0000, 8'h5A, "R5 close by we / R2");
        go_idle(); settle();
        write_byte(13'h1FFF, 8'hA5, 1, "R5");
        read_chk(13'h1FFF, 8'hA5, "R5 close by cs1");
        go_idle(); settle();
        write_byte(13'h0123, 8'h3C, 2, "R5");
        read_chk(13'h0123, 8'h3C, "R5 close by cs2");
        go_idle(); settle();

        // R7: A10 picks lane, A11 picks row, no aliasing
        write_byte(13'h0400, 8'h11, 0, "R7");
        write_byte(13'h0800, 8'h22, 0, "R7");
        write_byte(13'h0000, 8'h33, 0, "R7");
        read_chk(13'h0400, 8'h11, "R7 A10 lane");
        // R9: only the address changes while reading
        read_chk(13'h0800, 8'h22, "R9 address follow");
        read_chk(13'h0000, 8'h33, "R7 base");

        // R3: selected, output enable inactive
        oe_n_i = 1'b1;
        settle();
        push(1'b0, 1'b0, 8'h00, "R3");

        // R1: deselect combinations with read strobes active
        cs1_n_i = 1'b1; cs2_i = 1'b1; oe_n_i = 1'b0; we_n_i = 1'b1;
        settle();
        push(1'b0, 1'b0, 8'h00, "R1 cs1 high");
        cs1_n_i = 1'b0; cs2_i = 1'b0;
        settle();
        push(1'b0, 1'b0, 8'h00, "R1 cs2 low");
        go_idle(); settle();

        // R11: write strobe while deselected changes nothing
        addr_i = 13'h0000; dq_i = 8'hFF;
        cs1_n_i = 1'b1; cs2_i = 1'b1; we_n_i = 1'b0; oe_n_i = 1'b0;
        settle();
        push(1'b0, 1'b0, 8'h00, "R1 write strobe deselected");
        we_n_i = 1'b1; settle();
        cs1_n_i = 1'b0; cs2_i = 1'b0; we_n_i = 1'b0; settle();
        go_idle(); settle();
        read_chk(13'h0000, 8'h33, "R11");
        go_idle(); settle();

        // R4 / R6: write with output enable low, data replaced during and at close
        addr_i = 13'h0055; dq_i = 8'h0F;
        cs1_n_i = 1'b0; cs2_i = 1'b1; we_n_i = 1'b1; oe_n_i = 1'b1;
        settle();
        oe_n_i = 1'b0; we_n_i = 1'b0;
        settle();
        push(1'b0, 1'b0, 8'h00, "R4 oe low");
        dq_i = 8'h77;
        settle();
        we_n_i = 1'b1; dq_i = 8'hEE;
        settle();
        push(1'b1, 1'b1, 8'h77, "R6");
        go_idle(); settle();

        // R8: write strobe first, selects become active later
        addr_i = 13'h0200; dq_i = 8'h99;
        we_n_i = 1'b0; oe_n_i = 1'b0;
        settle();
        cs2_i = 1'b1;
        settle();
        push(1'b0, 1'b0, 8'h00, "R8 cs2 up");
        cs1_n_i = 1'b0;
        settle();
        push(1'b0, 1'b0, 8'h00, "R8 window open");
        we_n_i = 1'b1;
        settle();
        push(1'b1, 1'b1, 8'h99, "R8 written");
        go_idle(); settle();

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule